// File: doc/BRIEF.md
# I2C Bus Clear Recovery Engine

This block frees an I2C bus that a target device holds stuck. The usual cause is a target that stopped partway through a byte and keeps SDA low, so that no master can win arbitration. Software sets the pulse limit and the options, then commits them with a configuration-load handshake. The engine then toggles SCL. It samples SDA at the end of every high phase and stops pulsing as soon as the line reads high, or once the pulse limit is reached. If requested, it closes with a STOP condition.

On completion the engine latches a result bit, sets a done flag in the interrupt status register and clears its own enable. The done flag reaches the interrupt line only when its mask bit is set. Both bus lines are open-drain: the block only ever pulls a line low or lets it go. Every phase lasts a fixed number of ticks from an external clock divider.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset every register reads 0 (word addresses 0 to 4), neither bus line is pulled low and `irq` is low.
- R2: The configuration register at word address 0 reads back as written. The enable is bit 0, a stored terminate-request flag is bit 1, the STOP request is bit 2, and the pulse limit is the THR_W-bit field starting at bit 16.
- R3: A configuration write has no effect on the bus until bit 0 is written to the load register at word address 4. That register's bit 0 reads 1 for exactly one cycle after the write, while the new values are committed.
- R4: Each SCL pulse pulls SCL low for PHASE_TICKS ticks, then releases it for PHASE_TICKS ticks. Cycles without `tick` stretch the phase. SDA is not pulled low while pulsing.
- R5: SDA is sampled at the end of each SCL high phase. If it reads high, no further pulse is issued.
- R6: While SDA stays low, exactly as many pulses are issued as the pulse limit. A limit of 0 gives one pulse.
- R7: With the STOP request set, the engine closes with a STOP. SDA is pulled low only while SCL is low, then SCL is released, then SDA is released while SCL is high. Without the request, SDA is never pulled low.
- R8: On completion the engine does three things. It sets bit 11 of the interrupt status register (word address 2). It sets bit 0 of the result register (word address 1) to the last SDA sample, which is 1 when SDA was released. It clears the enable bit in the configuration readback.
- R9: `irq` is high exactly when status bit 11 and mask bit 11 (word address 3) are both 1. Writing 1 to status bit 11 clears it, and writing 0 leaves it unchanged. A completion in the same cycle as a clearing write leaves the bit set.
- R10: The result bit is read-only and keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Divider tick; phase counters advance only on it |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Masked completion interrupt |

## Verification
Completion setting the done flag and software writing 1 to clear it can land in the same cycle. The bench provokes this by watching the STOP's final SDA release on the pins. It then counts the release phase in clock cycles (one tick per cycle) and issues the clearing write in the cycle where the engine finishes. The flag must still read 1 afterwards, with `irq` high. A separate plain clearing write then shows that clearing does work outside the collision.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] A_ISR  = 3'd2;
   localparam logic [ADDR_W-1:0] A_IMR  = 3'd3;
   localparam logic [ADDR_W-1:0] A_LOAD = 3'd4;

   localparam int unsigned CFG_EN      = 0;
   localparam int unsigned CFG_TERM    = 1;
   localparam int unsigned CFG_STOP    = 2;
   localparam int unsigned CFG_THR_LSB = 16;
   localparam int unsigned IRQ_DONE    = 11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_SP_PRE,
      ST_SP_LOW,
      ST_SP_HIGH,
      ST_SP_REL,
      ST_FIN
   } bc_state_e;

endpackage

// File: rtl/bc_insync.sv
module bc_insync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bc_seq.sv
module bc_seq
   import i2cbc_pkg::*;
#(
   parameter int unsigned THR_W       = 5,
   parameter int unsigned PHASE_TICKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             go,
   input  logic             stop_req,
   input  logic [THR_W-1:0] thr,
   input  logic             sda_s,
   output logic             scl_low,
   output logic             sda_low,
   output logic             busy,
   output logic             done,
   output logic             ok
);

   localparam int unsigned     TCW     = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
   localparam logic [TCW-1:0] TC_LAST = TCW'(PHASE_TICKS - 1);

   bc_state_e        state_q;
   logic [TCW-1:0]   tcnt_q;
   logic [THR_W-1:0] pcnt_q;
   logic [THR_W-1:0] thr_q;
   logic             stop_q;
   logic             ok_q;

   logic [THR_W-1:0] thr_eff;
   logic [THR_W:0]   pcnt_nxt;
   logic             phase_end;
   logic             last_pulse;

   assign thr_eff    = (thr_q == '0) ? THR_W'(1) : thr_q;
   assign pcnt_nxt   = {1'b0, pcnt_q} + 1'b1;
   assign phase_end  = tick && (tcnt_q == TC_LAST);
   assign last_pulse = sda_s || (pcnt_nxt >= {1'b0, thr_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tcnt_q  <= '0;
         pcnt_q  <= '0;
         thr_q   <= '0;
         stop_q  <= 1'b0;
         ok_q    <= 1'b0;
      end else if (state_q == ST_IDLE) begin
         tcnt_q <= '0;
         if (go) begin
            state_q <= ST_LOW;
            pcnt_q  <= '0;
            thr_q   <= thr;
            stop_q  <= stop_req;
            ok_q    <= 1'b0;
         end
      end else if (state_q == ST_FIN) begin
         state_q <= ST_IDLE;
      end else if (tick) begin
         tcnt_q <= phase_end ? '0 : tcnt_q + 1'b1;
         if (phase_end) begin
            unique case (state_q)
               ST_LOW:     state_q <= ST_HIGH;
               ST_HIGH: begin
                  pcnt_q <= pcnt_nxt[THR_W-1:0];
                  ok_q   <= sda_s;
                  if (last_pulse) state_q <= stop_q ? ST_SP_PRE : ST_FIN;
                  else            state_q <= ST_LOW;
               end
               ST_SP_PRE:  state_q <= ST_SP_LOW;
               ST_SP_LOW:  state_q <= ST_SP_HIGH;
               ST_SP_HIGH: state_q <= ST_SP_REL;
               ST_SP_REL:  state_q <= ST_FIN;
               default:    state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign scl_low = (state_q == ST_LOW) || (state_q == ST_SP_PRE) || (state_q == ST_SP_LOW);
   assign sda_low = (state_q == ST_SP_LOW) || (state_q == ST_SP_HIGH);
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_FIN);
   assign ok      = ok_q;

   // R6: the pulse counter never passes the latched limit
   p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (pcnt_q <= thr_eff));

endmodule

// File: rtl/bc_regs.sv
module bc_regs
   import i2cbc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned THR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              seq_done,
   input  logic              seq_ok,
   output logic              run_en,
   output logic              run_stop,
   output logic [THR_W-1:0]  run_thr,
   output logic              irq
);

   logic             sh_en, sh_term, sh_stop;
   logic [THR_W-1:0] sh_thr;
   logic             act_en, act_stop;
   logic [THR_W-1:0] act_thr;
   logic             load_pend, stat_ok, isr_done, imr_done;
   logic             wr_cfg, wr_isr, wr_imr, wr_load;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;
   assign wr_cfg  = wr_en && (addr == A_CFG);
   assign wr_isr  = wr_en && (addr == A_ISR);
   assign wr_imr  = wr_en && (addr == A_IMR);
   assign wr_load = wr_en && (addr == A_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_en     <= 1'b0;
         sh_term   <= 1'b0;
         sh_stop   <= 1'b0;
         sh_thr    <= '0;
         act_en    <= 1'b0;
         act_stop  <= 1'b0;
         act_thr   <= '0;
         load_pend <= 1'b0;
         stat_ok   <= 1'b0;
         isr_done  <= 1'b0;
         imr_done  <= 1'b0;
      end else begin
         if (wr_cfg) begin
            sh_en   <= wdata[CFG_EN];
            sh_term <= wdata[CFG_TERM];
            sh_stop <= wdata[CFG_STOP];
            sh_thr  <= wdata[CFG_THR_LSB +: THR_W];
         end else if (seq_done) begin
            sh_en <= 1'b0;
         end
         load_pend <= wr_load && wdata[0];
         if (load_pend) begin
            act_en   <= sh_en;
            act_stop <= sh_stop;
            act_thr  <= sh_thr;
         end
         if (seq_done) act_en <= 1'b0;
         if (seq_done) stat_ok <= seq_ok;
         if (seq_done)                         isr_done <= 1'b1;
         else if (wr_isr && wdata[IRQ_DONE])   isr_done <= 1'b0;
         if (wr_imr) imr_done <= wdata[IRQ_DONE];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CFG: begin
            rdata[CFG_EN]                 = sh_en;
            rdata[CFG_TERM]               = sh_term;
            rdata[CFG_STOP]               = sh_stop;
            rdata[CFG_THR_LSB +: THR_W]   = sh_thr;
         end
         A_STAT: rdata[0]        = stat_ok;
         A_ISR:  rdata[IRQ_DONE] = isr_done;
         A_IMR:  rdata[IRQ_DONE] = imr_done;
         A_LOAD: rdata[0]        = load_pend;
         default: rdata = '0;
      endcase
   end

   assign run_en   = act_en;
   assign run_stop = act_stop;
   assign run_thr  = act_thr;
   assign irq      = isr_done & imr_done;

   // R8: completion raises the done flag
   p_done_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> isr_done);

   // R8: completion drops the committed enable
   p_done_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !act_en);

   // R10: result only moves on a completion
   p_result_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_done |=> $stable(stat_ok));

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
   import i2cbc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned THR_W       = 5,
   parameter int unsigned PHASE_TICKS = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              irq
);

   generate
      if (THR_W < 4 || THR_W > 15) begin : g_bad_thr_w
         $error("THR_W must lie in 4..15");
      end
      if (DATA_W < CFG_THR_LSB + THR_W) begin : g_bad_data_w
         $error("DATA_W too narrow for the pulse limit field");
      end
      if (PHASE_TICKS < 1) begin : g_bad_phase
         $error("PHASE_TICKS must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic             sda_s;
   logic             run_en, run_stop;
   logic [THR_W-1:0] run_thr;
   logic             seq_done, seq_ok, seq_busy;

   bc_insync #(.STAGES(SYNC_STAGES)) i_sda_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   bc_regs #(.DATA_W(DATA_W), .THR_W(THR_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .seq_done (seq_done),
      .seq_ok   (seq_ok),
      .run_en   (run_en),
      .run_stop (run_stop),
      .run_thr  (run_thr),
      .irq      (irq)
   );

   bc_seq #(.THR_W(THR_W), .PHASE_TICKS(PHASE_TICKS)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .go       (run_en),
      .stop_req (run_stop),
      .thr      (run_thr),
      .sda_s    (sda_s),
      .scl_low  (scl_oe),
      .sda_low  (sda_oe),
      .busy     (seq_busy),
      .done     (seq_done),
      .ok       (seq_ok)
   );

   // R7: SDA is pulled low only while SCL has been low for a cycle
   p_stop_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> (scl_oe && $past(scl_oe)));

   // R7: SDA is let go only while SCL is released
   p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (!scl_oe && !$past(scl_oe)));

   // R1: an idle engine pulls neither line
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/test_i2c_bus_unstick.sv
`timescale 1ns/1ps
module test_i2c_bus_unstick;

   localparam int DW = 32;
   localparam int TW = 5;
   localparam int PT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [DW-1:0] reg_wdata = '0;
   wire  [DW-1:0] reg_rdata;
   wire           sda_in;
   wire           scl_oe, sda_oe, irq;

   logic tgt_hold = 1'b0;
   bit   tick_alt = 1'b0;
   bit   finished = 1'b0;
   int   rel_after = 0;
   int   rise_cnt = 0, lo_run = 0, hi_run = 0;
   int   lo_min = 9999, lo_max = 0, hi_min = 9999, hi_max = 0;
   int   bad_stop = 0, sda_drv = 0;
   logic prev_scl = 1'b0, prev_sda = 1'b0;
   int   n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   assign sda_in = !(sda_oe || tgt_hold);

   i2c_bus_unstick #(.DATA_W(DW), .THR_W(TW), .PHASE_TICKS(PT), .SYNC_STAGES(2)) i_i2c_bus_unstick (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
   );

   always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

   // bus monitor and target model, sampled just after each rising edge
   always @(posedge clk) begin
      #1;
      if (scl_oe) lo_run++; else hi_run++;
      if (prev_scl && !scl_oe) begin
         rise_cnt++;
         if (lo_run < lo_min) lo_min = lo_run;
         if (lo_run > lo_max) lo_max = lo_run;
         lo_run = 0;
         if (rel_after > 0 && rise_cnt >= rel_after) tgt_hold = 1'b0;
      end
      if (!prev_scl && scl_oe) begin
         if (rise_cnt > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
         end
         hi_run = 0;
      end
      if (sda_oe && !prev_sda) begin
         sda_drv++;
         if (!(scl_oe && prev_scl)) bad_stop++;
      end
      if (!sda_oe && prev_sda) begin
         if (scl_oe || prev_scl) bad_stop++;
      end
      prev_scl = scl_oe;
      prev_sda = sda_oe;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #0.1;
      d = reg_rdata;
   endtask

   function automatic logic [DW-1:0] cfgw(input int thr, input bit stop, input bit en);
      logic [DW-1:0] w = '0;
      w[0] = en;
      w[1] = 1'b1;
      w[2] = stop;
      w[16 +: TW] = thr[TW-1:0];
      return w;
   endfunction

   task automatic arm(input int rel);
      tgt_hold  = (rel != 0);
      rel_after = rel;
      rise_cnt = 0; lo_run = 0; hi_run = 0;
      lo_min = 9999; lo_max = 0; hi_min = 9999; hi_max = 0;
      bad_stop = 0; sda_drv = 0;
   endtask

   task automatic start(input int thr, input bit stop);
      wr(3'd0, cfgw(thr, stop, 1'b0));
      wr(3'd0, cfgw(thr, stop, 1'b1));
      wr(3'd4, 32'd1);
   endtask

   task automatic wait_done();
      logic [DW-1:0] v;
      bit seen = 0;
      for (int i = 0; i < 3000; i++) begin
         rd(3'd2, v);
         if (v[11]) begin seen = 1; break; end
         @(negedge clk);
      end
      check(seen, "R8", "completion flag seen", seen, 1);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         check(v == '0, "R1", "register after reset", v, 0);
      end
      check(!scl_oe && !sda_oe, "R1", "lines released after reset", {scl_oe, sda_oe}, 0);
      check(!irq, "R1", "irq after reset", irq, 0);
   endtask

   task automatic t_cfg_readback();
      logic [DW-1:0] v;
      wr(3'd0, cfgw(9, 1'b1, 1'b0));
      rd(3'd0, v);
      check(v == cfgw(9, 1'b1, 1'b0), "R2", "config readback", v, cfgw(9, 1'b1, 1'b0));
   endtask

   task automatic t_load_gate();
      logic [DW-1:0] v;
      bit moved = 0;
      arm(3);
      wr(3'd0, cfgw(9, 1'b1, 1'b1));
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (scl_oe) moved = 1;
      end
      check(!moved, "R3", "bus idle before load", moved, 0);
      rd(3'd4, v);
      check(v[0] == 1'b0, "R3", "load bit before load", v[0], 0);
      wr(3'd4, 32'd1);
      rd(3'd4, v);
      check(v[0] == 1'b1, "R3", "load bit during commit", v[0], 1);
      @(negedge clk);
      rd(3'd4, v);
      check(v[0] == 1'b0, "R3", "load bit after commit", v[0], 0);
      wait_done();
      check(rise_cnt == 4, "R5", "SCL rises with early release plus STOP", rise_cnt, 4);
      check(bad_stop == 0, "R7", "STOP edge ordering", bad_stop, 0);
      check(sda_drv == 1, "R7", "SDA pulls with STOP", sda_drv, 1);
      rd(3'd1, v);
      check(v[0] == 1'b1, "R8", "result after release", v[0], 1);
      rd(3'd0, v);
      check(v == cfgw(9, 1'b1, 1'b0), "R8", "enable cleared in readback", v, cfgw(9, 1'b1, 1'b0));
      wr(3'd2, 32'h800);
   endtask

   task automatic t_stuck();
      logic [DW-1:0] v;
      arm(99);
      start(9, 1'b0);
      wait_done();
      check(rise_cnt == 9, "R6", "pulses on stuck line", rise_cnt, 9);
      check(sda_drv == 0, "R7", "no SDA pull without STOP", sda_drv, 0);
      rd(3'd1, v);
      check(v[0] == 1'b0, "R8", "result while stuck", v[0], 0);
      wr(3'd2, 32'h800);
   endtask

   task automatic t_thr_zero();
      logic [DW-1:0] v;
      arm(99);
      start(0, 1'b1);
      wait_done();
      check(rise_cnt == 2, "R6", "limit 0 gives one pulse plus STOP", rise_cnt, 2);
      check(bad_stop == 0 && sda_drv == 1, "R7", "STOP on stuck line", bad_stop, 0);
      rd(3'd1, v);
      check(v[0] == 1'b0, "R8", "result limit 0", v[0], 0);
      wr(3'd2, 32'h800);
   endtask

   task automatic t_phase();
      arm(99);
      start(3, 1'b0);
      wait_done();
      check(lo_min == PT && lo_max == PT, "R4", "low phase cycles", lo_max, PT);
      check(hi_min == PT && hi_max == PT, "R4", "high phase cycles", hi_max, PT);
      wr(3'd2, 32'h800);
      tick_alt = 1'b1;
      arm(99);
      start(2, 1'b0);
      wait_done();
      check(lo_min >= 2*PT-1 && lo_max <= 2*PT, "R4", "low phase at half tick rate", lo_max, 2*PT);
      tick_alt = 1'b0;
      wr(3'd2, 32'h800);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_irq();
      logic [DW-1:0] v;
      arm(2);
      start(9, 1'b0);
      wait_done();
      check(!irq, "R9", "irq masked", irq, 0);
      wr(3'd3, 32'h800);
      check(irq, "R9", "irq unmasked", irq, 1);
      wr(3'd2, 32'h0);
      rd(3'd2, v);
      check(v[11] == 1'b1, "R9", "writing 0 keeps flag", v[11], 1);
      wr(3'd2, 32'h800);
      rd(3'd2, v);
      check(v[11] == 1'b0 && !irq, "R9", "write 1 clears flag", v[11], 0);
   endtask

   task automatic t_collide();
      logic [DW-1:0] v;
      logic ps = 1'b0;
      bit found = 0;
      arm(1);
      start(9, 1'b1);
      for (int i = 0; i < 2000; i++) begin
         if (ps && !sda_oe) begin found = 1; break; end
         ps = sda_oe;
         @(negedge clk);
      end
      check(found, "R7", "STOP release observed", found, 1);
      repeat (PT) @(negedge clk);
      wr(3'd2, 32'h800);
      rd(3'd2, v);
      check(v[11] == 1'b1, "R9", "completion beats same-cycle clear", v[11], 1);
      check(irq, "R9", "irq after collision", irq, 1);
      rd(3'd1, v);
      check(v[0] == 1'b1, "R8", "result after one-pulse release", v[0], 1);
      wr(3'd2, 32'h800);
      rd(3'd2, v);
      check(v[11] == 1'b0, "R9", "plain clear after collision", v[11], 0);
   endtask

   task automatic t_sticky();
      logic [DW-1:0] v;
      repeat (30) @(negedge clk);
      rd(3'd1, v);
      check(v[0] == 1'b1, "R10", "result held while idle", v[0], 1);
      wr(3'd1, 32'h0);
      rd(3'd1, v);
      check(v[0] == 1'b1, "R10", "result ignores writes", v[0], 1);
      arm(99);
      start(4, 1'b0);
      wait_done();
      rd(3'd1, v);
      check(v[0] == 1'b0, "R10", "result replaced by next completion", v[0], 0);
      wr(3'd2, 32'h800);
      check(!scl_oe && !sda_oe, "R1", "lines released when idle", {scl_oe, sda_oe}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_readback();
      t_load_gate();
      t_stuck();
      t_thr_zero();
      t_phase();
      t_irq();
      t_collide();
      t_sticky();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule